// File: doc/BRIEF.md
# Subcode Q Word Receiver with CRC Check

This block gathers the subcode Q channel from a serial bit stream, one bit per strobe, into a 96-bit word. The first 80 bits are data and the last 16 bits are a check field. The block keeps a running CRC over the data bits and compares it with the inverted check field. When the 96th bit arrives it does three things. It pulls a ready line low for a fixed number of clocks. It latches a pass/fail flag. It loads a readout register that holds the flag followed by the 80 data bits.

A host waits for the falling edge of the ready line. It then samples the serial output and advances it one bit at a time with a step strobe. A sync marker restarts the word. Any bits gathered before the marker are thrown away and produce no ready pulse. With no sync marker, a new word begins right after the 96th bit.

Top module: `subq_receiver`

## Requirements
- R1: A word is 96 strobed bits: 80 data bits, then 16 check bits. Once the 96th bit is taken, the next strobed bit is the first bit of a new word, with no sync needed.
- R2: `ready_n` falls only in the clock after the 96th bit of a word is strobed. A word cut short never makes it fall.
- R3: A `sq_sync` pulse discards the word in progress and restarts the count. A strobe in the same cycle as the sync is taken as bit 1 of the new word.
- R4: The readout register is reloaded only on the clock where `ready_n` falls. `rd_data` holds its value unless `rd_step` is high or a reload happens. Each `rd_step` moves the next bit onto `rd_data`. After the last data bit has been stepped out, `rd_data` reads 0.
- R5: The CRC is CRC-16 with polynomial x^16+x^12+x^5+1 and initial value 0. It runs over the 80 data bits in arrival order. The first check bit received is the check field's MSB. The check passes when the computed CRC equals the bitwise inverse of the received check field. `crc_ok` shows the result of the latest complete word and is 1 on pass.
- R6: Every `ready_n` low pulse lasts exactly `PULSE_CYCLES` clocks.
- R7: The readout order starts with the pass flag, which is on `rd_data` at the fall. Then come data bytes 0 to 9 in arrival order. Within each byte the last-arrived bit comes out first, so the first-arrived bit of each byte is treated as its MSB and the byte leaves LSB first.
- R8: After reset, `ready_n` is 1, `crc_ok` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sq_bit | input | 1 | Subcode Q bit value |
| sq_strobe | input | 1 | One-cycle strobe that takes `sq_bit` |
| sq_sync | input | 1 | One-cycle subcode sync marker |
| rd_step | input | 1 | One-cycle host request to advance the readout |
| ready_n | output | 1 | Active-low word-ready pulse |
| rd_data | output | 1 | Serial readout bit |
| crc_ok | output | 1 | CRC pass flag of the latest word |

## Verification
The hardest case to reach from the ports is a word cut off just short of the end. The stimulus sends 95 bits, then a sync, then a full word. If the count leaks across the sync, a ready pulse comes out at the wrong point. The scoreboard catches this as a fall with no expected word queued. A sync that lands together with the first strobe is also sent. So are back-to-back words with no sync between them, which checks the wrap after bit 96. Corrupted words check both a bad data bit and a bad check bit.

// File: rtl/subq_receiver.sv
module subq_receiver #(
  parameter int DATA_BITS    = 80,
  parameter int CRC_BITS     = 16,
  parameter int PULSE_CYCLES = 4,
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sq_bit,
  input  logic sq_strobe,
  input  logic sq_sync,
  input  logic rd_step,
  output logic ready_n,
  output logic rd_data,
  output logic crc_ok
);
  localparam int WORD_BITS = DATA_BITS + CRC_BITS;
  localparam int CW        = $clog2(WORD_BITS + 1);
  localparam int PW        = $clog2(PULSE_CYCLES + 1);
  localparam int OUT_BITS  = DATA_BITS + 1;

  logic [CW-1:0]        cnt, cnt_base;
  logic [CRC_BITS-1:0]  crc, crc_base, crc_next, rx_crc, rx_crc_next;
  logic [DATA_BITS-1:0] dat, ordered;
  logic [OUT_BITS-1:0]  rd_sh;
  logic [PW-1:0]        pcnt;
  logic                 in_data, last, pass;

  assign cnt_base    = sq_sync ? '0 : cnt;
  assign crc_base    = sq_sync ? '0 : crc;
  assign in_data     = cnt_base < CW'(DATA_BITS);
  assign last        = sq_strobe && (cnt_base == CW'(WORD_BITS - 1));
  assign crc_next    = {crc_base[CRC_BITS-2:0], 1'b0}
                     ^ ({CRC_BITS{crc_base[CRC_BITS-1] ^ sq_bit}} & POLY[CRC_BITS-1:0]);
  assign rx_crc_next = {rx_crc[CRC_BITS-2:0], sq_bit};
  assign pass        = (crc_base == ~rx_crc_next);

  for (genvar k = 0; k < DATA_BITS; k++) begin : g_order
    assign ordered[k] = dat[DATA_BITS - 1 - (8 * (k / 8) + 7 - (k % 8))];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      crc    <= '0;
      rx_crc <= '0;
      dat    <= '0;
    end else if (sq_strobe) begin
      cnt <= last ? '0 : cnt_base + 1'b1;
      if (in_data) begin
        crc <= crc_next;
        dat <= {dat[DATA_BITS-2:0], sq_bit};
      end else begin
        rx_crc <= rx_crc_next;
        if (last) crc <= '0;
      end
    end else if (sq_sync) begin
      cnt <= '0;
      crc <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sh  <= '0;
      crc_ok <= 1'b0;
      pcnt   <= '0;
    end else begin
      if (last) begin
        rd_sh  <= {ordered, pass};
        crc_ok <= pass;
        pcnt   <= PW'(PULSE_CYCLES);
      end else begin
        if (rd_step) rd_sh <= {1'b0, rd_sh[OUT_BITS-1:1]};
        if (pcnt != '0) pcnt <= pcnt - 1'b1;
      end
    end
  end

  assign ready_n = (pcnt == '0);
  assign rd_data = rd_sh[0];

  logic [PW-1:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= '0;
    else if (!ready_n) low_cnt <= low_cnt + 1'b1;
    else               low_cnt <= '0;
  end

  a_r1_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(WORD_BITS));
  a_r2_fall_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> $past(sq_strobe && !sq_sync && cnt == CW'(WORD_BITS - 1)));
  a_r3_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    sq_sync && !sq_strobe |=> cnt == '0);
  a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_step |=> $stable(rd_data) || $fell(ready_n));
  a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ready_n |=> $stable(crc_ok) || $fell(ready_n));
  a_r6_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n |-> low_cnt < PW'(PULSE_CYCLES));
  a_r6_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_n) |-> $past(low_cnt) == PW'(PULSE_CYCLES - 1));
endmodule

// File: tb/subq_receiver_bench.sv
module subq_receiver_bench;
  localparam int PULSE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sq_bit = 1'b0, sq_strobe = 1'b0, sq_sync = 1'b0, rd_step = 1'b0;
  logic ready_n, rd_data, crc_ok;

  int tests = 0, fails = 0, falls = 0, pushed = 0;
  bit busy = 1'b0, finished = 1'b0;
  logic [80:0] exp_q[$];

  always #10 clk = ~clk;

  subq_receiver #(.PULSE_CYCLES(PULSE)) u_subq_receiver (
    .clk(clk), .rst_n(rst_n), .sq_bit(sq_bit), .sq_strobe(sq_strobe),
    .sq_sync(sq_sync), .rd_step(rd_step), .ready_n(ready_n),
    .rd_data(rd_data), .crc_ok(crc_ok));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc16(input logic [79:0] d);
    logic [15:0] c = '0;
    for (int i = 79; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  function automatic logic [80:0] build_exp(input logic [79:0] d, input logic [15:0] cw);
    logic [80:0] e;
    e[0] = (crc16(d) == ~cw);
    for (int b = 0; b < 10; b++)
      for (int i = 0; i < 8; i++)
        e[1 + 8*b + i] = d[79 - (8*b + 7 - i)];
    return e;
  endfunction

  task automatic strobe_bit(input logic v, input logic s);
    @(negedge clk); sq_bit = v; sq_strobe = 1'b1; sq_sync = s;
    @(negedge clk); sq_strobe = 1'b0; sq_sync = 1'b0;
    @(negedge clk);
  endtask

  task automatic sync_pulse();
    @(negedge clk); sq_sync = 1'b1;
    @(negedge clk); sq_sync = 1'b0;
  endtask

  // smode: 0 no sync, 1 separate sync first, 2 sync with first strobe
  task automatic send_word(input logic [79:0] d, input logic [15:0] cw, input int smode);
    if (smode == 1) sync_pulse();
    exp_q.push_back(build_exp(d, cw));
    pushed++;
    for (int i = 0; i < 96; i++)
      strobe_bit(i < 80 ? d[79 - i] : cw[15 - (i - 80)], (smode == 2) && (i == 0));
  endtask

  task automatic send_partial(input int n);
    sync_pulse();
    for (int i = 0; i < n; i++) strobe_bit(i[0], 1'b0);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || busy) @(negedge clk);
  endtask

  // monitor: scoreboard pop and serial readout
  initial begin
    logic prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !ready_n) begin
        logic [80:0] e;
        falls++;
        busy = 1'b1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected ready fall", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(crc_ok == e[0], "R5 crc_ok flag", crc_ok, e[0]);
          chk(rd_data == e[0], "R7 flag first on rd_data", rd_data, e[0]);
          @(negedge clk); @(negedge clk);
          chk(rd_data == e[0], "R4 rd_data holds without step", rd_data, e[0]);
          for (int k = 1; k <= 80; k++) begin
            @(negedge clk); rd_step = 1'b1;
            @(negedge clk); rd_step = 1'b0;
            chk(rd_data == e[k], $sformatf("R7 readout bit %0d", k), rd_data, e[k]);
          end
          @(negedge clk); rd_step = 1'b1;
          @(negedge clk); rd_step = 1'b0;
          chk(rd_data == 1'b0, "R4 zero after last bit", rd_data, 0);
        end
        busy = 1'b0;
        prev = 1'b0;
      end else begin
        prev = ready_n;
      end
    end
  end

  // pulse width monitor
  initial begin
    int run = 0;
    forever begin
      @(negedge clk);
      if (!ready_n) run++;
      else if (run != 0) begin
        chk(run == PULSE, "R6 ready pulse width", run, PULSE);
        run = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [79:0] d;
    repeat (3) @(negedge clk);
    chk(ready_n == 1'b1, "R8 ready_n after reset", ready_n, 1);
    chk(crc_ok == 1'b0, "R8 crc_ok after reset", crc_ok, 0);
    chk(rd_data == 1'b0, "R8 rd_data after reset", rd_data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    d = 80'h0;
    send_word(d, ~crc16(d), 1);                      // R5 all-zero good word
    d = 80'h0123_4567_89AB_CDEF_0011;
    send_word(d, ~crc16(d), 0);                      // R1 back-to-back, no sync
    wait_idle();
    d = 80'hFFFF_FFFF_FFFF_FFFF_FFFF;
    send_word(d, ~crc16(d) ^ 16'h0100, 1);           // R5 bad check bit
    wait_idle();
    d = 80'hA5A5_5A5A_C3C3_3C3C_9669;
    send_word(d ^ 80'h1, ~crc16(d), 2);              // R3 sync with first strobe, R5 bad data bit
    wait_idle();

    send_partial(95);                                // R3 abort one bit short
    repeat (10) @(negedge clk);
    chk(ready_n == 1'b1, "R2 no fall on 95 bits", ready_n, 1);
    chk(crc_ok == 1'b0, "R3 flag untouched by partial", crc_ok, 0);
    d = 80'h8000_0000_0000_0000_0001;
    send_word(d, ~crc16(d), 1);                      // R3 full word after abort
    wait_idle();
    send_partial(40);
    d = 80'h1357_9BDF_2468_ACE0_FEDC;
    send_word(d, ~crc16(d), 2);                      // R3 sync+strobe discards partial
    wait_idle();
    repeat (20) @(negedge clk);

    chk(falls == pushed, "R2 one fall per complete word", falls, pushed);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule